// File: doc/BRIEF.md
# Canonical Huffman Symbol Decoder

This block holds the code tables for the entropy stage of a baseline image decoder and turns a serial bitstream into 8-bit symbols. Four table classes are stored side by side: DC luma (class 0), DC chroma (class 1), AC luma (class 2) and AC chroma (class 3). For each class and each code length from 1 to 16, the block keeps three values: the smallest code of that length, the largest code of that length, and where the symbol of that smallest code sits in the class's region of one shared symbol store.

Software fills the tables through a small write port. A select write chooses the table part, an address write sets a pointer, and each data write stores one word at the pointer and then advances it. For a decode, the caller pulses a start with a class number and then feeds bits, most significant first, one per cycle. The block extends the code by one bit on every accepted bit and compares the code with the bounds stored for the current length. On a match it emits the symbol and the code length. If no length up to 16 matches, it flags an error and holds that state until reset.

Top module: `hufdec_top`

## Requirements
- R1: After reset, `sym_valid`, `dec_busy` and `dec_err` are 0.
- R2: `cfg_sel` picks the target of data writes: 0 = smallest code, 1 = largest code, 2 = offset, 3 = symbol store. For values 0 to 2 the pointer indexes entry class*16 + (length-1). For value 3 the pointer is the absolute symbol-store address. Each `cfg_data_we` writes at the pointer and then advances the pointer by one. A later write to an entry replaces its content.
- R3: The symbol regions start at fixed bases: class 0 at 0, class 1 at 12, class 2 at 24, class 3 at 186, for 348 entries in all. A matched code of length L reads address base(class) + offset[L] + (code - smallest[L]).
- R4: `dec_start` in idle latches `dec_class` and raises `dec_busy`. While busy, each cycle with `bit_valid` high shifts in `bit_in`, most significant bit first. A code of length L matches when smallest[L] <= code <= largest[L].
- R5: A match raises `sym_valid` for exactly one cycle, at the clock edge that accepts the last bit. `sym_out` and `sym_len` are valid in that cycle, and `dec_busy` returns to 0. No symbol is emitted for earlier bits of the code.
- R6: A length whose smallest-code entry is 0xFFFF holds no codes and never matches.
- R7: Codes of the full 16-bit length decode like shorter ones.
- R8: If the 16th bit gives no match, `dec_err` rises at that edge and stays high. `sym_valid` stays low, `dec_busy` drops, and `dec_start` has no effect until reset. Reset clears the error but keeps the loaded tables.
- R9: Each class decodes only from its own bounds and its own symbol region. The same bits can give different results in different classes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel_we | input | 1 | Load the table-part select |
| cfg_sel | input | 2 | Table part: 0 smallest, 1 largest, 2 offset, 3 symbol |
| cfg_addr_we | input | 1 | Load the write pointer |
| cfg_addr | input | 9 | New write pointer |
| cfg_data_we | input | 1 | Write one word at the pointer, then advance it |
| cfg_data | input | 16 | Write data (symbols use the low 8 bits) |
| dec_start | input | 1 | Begin decoding one symbol |
| dec_class | input | 2 | Table class for this symbol |
| bit_valid | input | 1 | `bit_in` carries a bit |
| bit_in | input | 1 | Serial code bit, MSB first |
| dec_busy | output | 1 | Decoding in progress, bits accepted |
| sym_valid | output | 1 | One-cycle symbol strobe |
| sym_out | output | 8 | Decoded symbol |
| sym_len | output | 5 | Code length of the symbol |
| dec_err | output | 1 | No code matched; sticky until reset |

## Verification
Every result is registered once. The symbol, length and strobe appear right after the edge that takes the final bit. Busy follows one edge after the start pulse. The error flag follows the edge that takes the 16th bit. Each scenario task drives inputs 1 ns after a rising edge and samples 1 ns after the next rising edge, so it reads the new register values there. During the earlier bits of a code the task records any strobe, so an early match is caught. One edge after a match it checks that the strobe has fallen again.

// File: rtl/hufdec_pkg.sv
package hufdec_pkg;
    typedef enum logic [1:0] {
        SEL_START  = 2'd0,
        SEL_MAX    = 2'd1,
        SEL_OFFSET = 2'd2,
        SEL_SYMBOL = 2'd3
    } tbl_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } dec_state_e;
endpackage

// File: rtl/hufdec_loader.sv
module hufdec_loader
    import hufdec_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_we,
    input  logic [1:0]        sel,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              data_we,
    output tbl_sel_e          wr_sel,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic              wr_en
);
    typedef struct packed {
        tbl_sel_e          sel;
        logic [ADDR_W-1:0] ptr;
    } ld_t;

    ld_t ld_d, ld_q;

    always_comb begin
        ld_d = ld_q;
        if (sel_we) ld_d.sel = tbl_sel_e'(sel);
        if (addr_we)      ld_d.ptr = addr;
        else if (data_we) ld_d.ptr = ld_q.ptr + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ld_q <= '{sel: SEL_START, ptr: '0};
        else        ld_q <= ld_d;
    end

    assign wr_sel = ld_q.sel;
    assign wr_ptr = ld_q.ptr;
    assign wr_en  = data_we;

    // R2: a data write alone moves the pointer by one
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !addr_we) |=> (wr_ptr == $past(wr_ptr) + 1'b1));
endmodule

// File: rtl/hufdec_bounds.sv
module hufdec_bounds
    import hufdec_pkg::*;
#(
    parameter int CODE_W  = 16,
    parameter int N_CLASS = 4,
    parameter int N_LEN   = 16,
    parameter int IDX_W   = $clog2(N_CLASS * N_LEN)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  tbl_sel_e          wr_sel,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [CODE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CODE_W-1:0] rd_start,
    output logic [CODE_W-1:0] rd_max,
    output logic [CODE_W-1:0] rd_off
);
    localparam int ENTRIES = N_CLASS * N_LEN;
    localparam int N_PART  = 3;

    logic [N_PART-1:0][CODE_W-1:0] rd_val;

    for (genvar k = 0; k < N_PART; k++) begin : g_part
        logic [CODE_W-1:0] tbl [ENTRIES];
        always_ff @(posedge clk) begin
            if (wr_en && (wr_sel == tbl_sel_e'(k))) tbl[wr_idx] <= wr_data;
        end
        assign rd_val[k] = tbl[rd_idx];
    end

    assign rd_start = rd_val[0];
    assign rd_max   = rd_val[1];
    assign rd_off   = rd_val[2];
endmodule

// File: rtl/hufdec_symmem.sv
module hufdec_symmem #(
    parameter int SYM_W  = 8,
    parameter int DEPTH  = 348,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SYM_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [SYM_W-1:0]  rd_data
);
    logic [SYM_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < DEPTH)) mem[wr_addr] <= wr_data;
    end

    assign rd_data = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : '0;
endmodule

// File: rtl/hufdec_top.sv
module hufdec_top
    import hufdec_pkg::*;
#(
    parameter int CODE_W  = 16,
    parameter int SYM_W   = 8,
    parameter int N_LEN   = 16,
    parameter int DC_SYMS = 12,
    parameter int AC_SYMS = 162,
    parameter int ADDR_W  = $clog2(2 * (DC_SYMS + AC_SYMS)),
    parameter int LEN_W   = $clog2(N_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sel_we,
    input  logic [1:0]        cfg_sel,
    input  logic              cfg_addr_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_data_we,
    input  logic [CODE_W-1:0] cfg_data,
    input  logic              dec_start,
    input  logic [1:0]        dec_class,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic              dec_busy,
    output logic              sym_valid,
    output logic [SYM_W-1:0]  sym_out,
    output logic [LEN_W-1:0]  sym_len,
    output logic              dec_err
);
    localparam int N_CLASS   = 4;
    localparam int LIDX_W    = $clog2(N_LEN);
    localparam int IDX_W     = $clog2(N_CLASS * N_LEN);
    localparam int SYM_DEPTH = 2 * (DC_SYMS + AC_SYMS);

    function automatic logic [ADDR_W-1:0] class_base(input logic [1:0] c);
        case (c)
            2'd0:    return '0;
            2'd1:    return ADDR_W'(DC_SYMS);
            2'd2:    return ADDR_W'(2 * DC_SYMS);
            default: return ADDR_W'(2 * DC_SYMS + AC_SYMS);
        endcase
    endfunction

    tbl_sel_e          ld_sel;
    logic [ADDR_W-1:0] ld_ptr;
    logic              ld_we;

    hufdec_loader #(.ADDR_W(ADDR_W)) loader_i (
        .clk(clk), .rst_n(rst_n),
        .sel_we(cfg_sel_we), .sel(cfg_sel),
        .addr_we(cfg_addr_we), .addr(cfg_addr),
        .data_we(cfg_data_we),
        .wr_sel(ld_sel), .wr_ptr(ld_ptr), .wr_en(ld_we)
    );

    logic tbl_we, sym_we;
    assign tbl_we = ld_we && (ld_sel != SEL_SYMBOL) && (int'(ld_ptr) < N_CLASS * N_LEN);
    assign sym_we = ld_we && (ld_sel == SEL_SYMBOL);

    typedef struct packed {
        dec_state_e        st;
        logic [1:0]        cls;
        logic [CODE_W-1:0] code;
        logic [LEN_W-1:0]  len;
        logic              vld;
        logic [SYM_W-1:0]  sym;
        logic [LEN_W-1:0]  olen;
        logic              err;
    } dec_t;

    dec_t dec_d, dec_q;

    logic [IDX_W-1:0]  rd_idx;
    logic [CODE_W-1:0] rd_start, rd_max, rd_off;
    logic [ADDR_W-1:0] sym_addr;
    logic [SYM_W-1:0]  rd_sym;
    logic [CODE_W-1:0] code_n;
    logic              hit;

    assign rd_idx = {dec_q.cls, dec_q.len[LIDX_W-1:0]};

    hufdec_bounds #(.CODE_W(CODE_W), .N_CLASS(N_CLASS), .N_LEN(N_LEN), .IDX_W(IDX_W)) bounds_i (
        .clk(clk), .wr_en(tbl_we), .wr_sel(ld_sel),
        .wr_idx(ld_ptr[IDX_W-1:0]), .wr_data(cfg_data),
        .rd_idx(rd_idx), .rd_start(rd_start), .rd_max(rd_max), .rd_off(rd_off)
    );

    hufdec_symmem #(.SYM_W(SYM_W), .DEPTH(SYM_DEPTH), .ADDR_W(ADDR_W)) symmem_i (
        .clk(clk), .wr_en(sym_we), .wr_addr(ld_ptr), .wr_data(cfg_data[SYM_W-1:0]),
        .rd_addr(sym_addr), .rd_data(rd_sym)
    );

    assign code_n   = {dec_q.code[CODE_W-2:0], bit_in};
    assign hit      = (rd_start != '1) && (code_n >= rd_start) && (code_n <= rd_max);
    assign sym_addr = class_base(dec_q.cls) + ADDR_W'(rd_off) + ADDR_W'(code_n - rd_start);

    always_comb begin
        dec_d     = dec_q;
        dec_d.vld = 1'b0;
        case (dec_q.st)
            ST_IDLE: if (dec_start) begin
                dec_d.st   = ST_RUN;
                dec_d.cls  = dec_class;
                dec_d.code = '0;
                dec_d.len  = '0;
            end
            ST_RUN: if (bit_valid) begin
                dec_d.code = code_n;
                dec_d.len  = dec_q.len + 1'b1;
                if (hit) begin
                    dec_d.vld  = 1'b1;
                    dec_d.sym  = rd_sym;
                    dec_d.olen = dec_q.len + 1'b1;
                    dec_d.st   = ST_IDLE;
                end else if (dec_q.len == LEN_W'(N_LEN - 1)) begin
                    dec_d.err = 1'b1;
                    dec_d.st  = ST_HALT;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '{st: ST_IDLE, default: '0};
        else        dec_q <= dec_d;
    end

    assign dec_busy  = (dec_q.st == ST_RUN);
    assign sym_valid = dec_q.vld;
    assign sym_out   = dec_q.sym;
    assign sym_len   = dec_q.olen;
    assign dec_err   = dec_q.err;

    // R5: the symbol strobe lasts one cycle
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> !sym_valid);
    // R5: a symbol only follows a cycle spent decoding
    a_r5_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> $past(dec_busy));
    // R7: reported lengths stay within 1..N_LEN
    a_r7_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> (sym_len >= 1 && int'(sym_len) <= N_LEN));
    // R8: the error is sticky and silences the decoder
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |=> dec_err);
    a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> (!sym_valid && !dec_busy));
endmodule

// File: tb/hufdec_tb.sv
`timescale 1ns/1ps
module hufdec_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sel_we = 0, cfg_addr_we = 0, cfg_data_we = 0;
    logic [1:0]  cfg_sel = 0;
    logic [8:0]  cfg_addr = 0;
    logic [15:0] cfg_data = 0;
    logic        dec_start = 0, bit_valid = 0, bit_in = 0;
    logic [1:0]  dec_class = 0;
    logic        dec_busy, sym_valid, dec_err;
    logic [7:0]  sym_out;
    logic [4:0]  sym_len;

    int n_chk = 0, n_bad = 0;
    logic [15:0] t_st [64];
    logic [15:0] t_mx [64];
    logic [15:0] t_of [64];

    always #5 clk = ~clk;

    hufdec_top dut_i (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic set_sel(input logic [1:0] s);
        cfg_sel_we = 1; cfg_sel = s; tick(); cfg_sel_we = 0;
    endtask
    task automatic set_addr(input logic [8:0] a);
        cfg_addr_we = 1; cfg_addr = a; tick(); cfg_addr_we = 0;
    endtask
    task automatic put(input logic [15:0] d);
        cfg_data_we = 1; cfg_data = d; tick(); cfg_data_we = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; tick(); tick(); rst_n = 1; tick();
    endtask

    // Tables: entry = class*16 + (length-1); 0xFFFF marks an empty length
    task automatic load_tables();
        for (int i = 0; i < 64; i++) begin t_st[i] = 16'hFFFF; t_mx[i] = 16'hFFFF; t_of[i] = 0; end
        t_st[1]  = 0;  t_mx[1]  = 2;  t_of[1]  = 0;   // class0 L2: 00,01,10
        t_st[2]  = 6;  t_mx[2]  = 6;  t_of[2]  = 3;   // class0 L3: 110
        t_st[16] = 0;  t_mx[16] = 0;  t_of[16] = 0;   // class1 L1: 0
        t_st[17] = 2;  t_mx[17] = 2;  t_of[17] = 1;   // class1 L2: 10
        t_st[33] = 0;  t_mx[33] = 0;  t_of[33] = 0;   // class2 L2: 00
        t_st[47] = 16'h8000; t_mx[47] = 16'h8001; t_of[47] = 1; // class2 L16
        t_st[48] = 0;  t_mx[48] = 0;  t_of[48] = 0;   // class3 L1: 0
        set_sel(0); set_addr(0); for (int i = 0; i < 64; i++) put(t_st[i]);
        set_sel(1); set_addr(0); for (int i = 0; i < 64; i++) put(t_mx[i]);
        set_sel(2); set_addr(0); for (int i = 0; i < 64; i++) put(t_of[i]);
        set_sel(3);
        set_addr(0);   put(16'h05); put(16'h11); put(16'h22); put(16'h33);
        set_addr(12);  put(16'hA0); put(16'hA1);
        set_addr(24);  put(16'h01); put(16'hF0); put(16'hF1);
        set_addr(186); put(16'h77);
    endtask

    task automatic run_code(input logic [1:0] cls, input logic [15:0] bits, input int n,
                            input logic [7:0] esym, input logic [4:0] elen, input string tag);
        bit early = 0;
        logic v; logic [7:0] s; logic [4:0] l;
        dec_start = 1; dec_class = cls; tick(); dec_start = 0;
        check(dec_busy === 1'b1, {tag, " R4 busy after start"}, dec_busy, 1);
        for (int i = n - 1; i >= 0; i--) begin
            bit_valid = 1; bit_in = bits[i]; tick();
            if (i > 0 && sym_valid) early = 1;
        end
        v = sym_valid; s = sym_out; l = sym_len;
        bit_valid = 0;
        check(!early, {tag, " R5 no early symbol"}, early, 0);
        check(v === 1'b1 && s === esym, {tag, " R4 symbol"}, s, esym);
        check(l === elen, {tag, " R5 length"}, l, elen);
        tick();
        check(sym_valid === 1'b0 && dec_busy === 1'b0, {tag, " R5 pulse ends"}, sym_valid, 0);
    endtask

    task automatic t_reset();
        check(sym_valid === 0 && dec_busy === 0 && dec_err === 0, "R1 reset state",
              {sym_valid, dec_busy, dec_err}, 0);
    endtask

    task automatic t_dc_luma();
        run_code(0, 16'b00, 2, 8'h05, 2, "R4 c0 00");
        run_code(0, 16'b01, 2, 8'h11, 2, "R4 c0 01");
        run_code(0, 16'b10, 2, 8'h22, 2, "R4 c0 10");
        run_code(0, 16'b110, 3, 8'h33, 3, "R3 c0 110");
    endtask

    task automatic t_classes();
        run_code(1, 16'b0, 1, 8'hA0, 1, "R9 c1 0");
        run_code(1, 16'b10, 2, 8'hA1, 2, "R3 c1 base12");
        run_code(3, 16'b0, 1, 8'h77, 1, "R3 c3 base186");
    endtask

    task automatic t_empty_len();
        run_code(2, 16'b00, 2, 8'h01, 2, "R6 c2 empty L1");
    endtask

    task automatic t_long();
        run_code(2, 16'h8000, 16, 8'hF0, 16, "R7 c2 L16 first");
        run_code(2, 16'h8001, 16, 8'hF1, 16, "R7 c2 L16 second");
    endtask

    task automatic t_reload();
        set_sel(3); set_addr(1); put(16'h5A);
        run_code(0, 16'b01, 2, 8'h5A, 2, "R2 reload symbol");
    endtask

    task automatic t_error();
        bit seen = 0;
        dec_start = 1; dec_class = 3; tick(); dec_start = 0;
        for (int i = 0; i < 16; i++) begin
            bit_valid = 1; bit_in = 1; tick();
            if (sym_valid) seen = 1;
            if (i < 15 && dec_err) seen = 1;
        end
        bit_valid = 0;
        check(!seen, "R8 nothing before 16th bit", seen, 0);
        check(dec_err === 1 && dec_busy === 0, "R8 error raised", {dec_err, dec_busy}, 2);
        dec_start = 1; dec_class = 3; tick(); dec_start = 0;
        check(dec_busy === 0 && dec_err === 1, "R8 start ignored", {dec_err, dec_busy}, 2);
        bit_valid = 1; bit_in = 0; tick(); bit_valid = 0;
        check(sym_valid === 0 && dec_err === 1, "R8 bits ignored", {sym_valid, dec_err}, 1);
        do_reset();
        check(dec_err === 0, "R8 reset clears error", dec_err, 0);
        run_code(3, 16'b0, 1, 8'h77, 1, "R8 tables kept");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2;
        tick(); tick();
        t_reset();
        rst_n = 1; tick();
        t_reset();
        load_tables();
        t_dc_luma();
        t_classes();
        t_empty_len();
        t_long();
        t_reload();
        t_error();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule